// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a 32-bit down-counter for local interrupt generation. It is paced by a bus-clock enable (`tick_en`) divided by a programmable power-of-two prescaler. Software loads a start value. The count then falls by one per prescaler step until it expires. A one-shot timer stops at zero. A periodic timer reloads its start value and keeps running.

Each expiry adds one to a pending-event counter. The interrupt side is a valid/ready stream: `irq_valid` stays high while events are pending and the timer's interrupt entry is unmasked, and `irq_vector` carries the entry's vector. Each cycle with both `irq_valid` and `irq_ready` high consumes one pending event. While `irq_ready` is low, events build up in the pending counter, which saturates. `irq_valid` does not drop until its handshake completes, unless software masks or disables the entry.

The register port is a single-cycle write strobe with a combinational read. Address 0 holds the start value and address 1 holds the current count. Address 2 holds the divide setting and address 3 holds the interrupt entry. A plain `sw_en` pin is the software enable.

Top module: `cd_timer`

## Requirements
- R1: The step period is 2^e cycles of `tick_en`, where e = ({div[3],div[1],div[0]} + 1) mod 8. So 000 gives 2, 001 gives 4, and so on up to 110, which gives 128. The setting 111 gives 1. Bit 2 of the divide register has no effect on the period.
- R2: A write to address 0 loads both the start value and the current count, and clears the prescaler phase. The first decrement comes exactly one full step period after the write edge. This also applies when the write lands on a running count.
- R3: With a start value of 0 the timer is stopped. The current count reads 0 and no expiry occurs.
- R4: In one-shot mode (entry bit 17 clear) the count falls to 0 and stays there until the next write to address 0. The run produces exactly one expiry.
- R5: In periodic mode (entry bit 17 set), each step that would reach 0 instead reloads the start value. Every such step counts as one expiry.
- R6: Each expiry adds one to the pending counter, which saturates at 2^PEND_W-1. `irq_valid` is high while the pending counter is nonzero and entry bit 16 (mask) is clear. Each cycle with `irq_valid` and `irq_ready` both high removes one pending event. `irq_vector` equals entry bits 7:0.
- R7: While `sw_en` is low, the mask bit is forced to 1 and a write cannot clear it. In the same condition the pending counter is held at 0.
- R8: The interrupt entry reads back with bit 16 as the mask, bit 17 as periodic, bit 12 as `irq_valid` (read-only) and bits 7:0 as the vector. All other bits read 0. The divide register keeps bits 3:0 and reads 0 elsewhere. Writes to address 1 are ignored.
- R9: After reset, the start value, current count and divide register are 0. The entry reads 0x00010000 and `irq_valid` is low.
- R10: A write to the divide register does not change the running step. The new period takes effect at the next prescaler step, or at a write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Bus-clock enable feeding the prescaler |
| sw_en | input | 1 | Software enable; low masks the entry and clears pending events |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 start, 1 current, 2 divide, 3 entry) |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Register read data for `addr` (combinational) |
| irq_valid | output | 1 | Interrupt event available |
| irq_ready | input | 1 | Consumer accepts one event |
| irq_vector | output | VEC_W | Vector of the pending interrupt |

## Verification
The hardest cases to reach are a periodic count that expires several times within one observation window, and a divide change that arrives in the middle of a step period. Only the count and the stream are visible at the ports, so the bench sweeps every divide encoding with tiny start values. It reads the current count at computed cycle offsets, then stops `tick_en` and drains the stream to count the expiries. To catch the deferred divide, the bench writes the new setting one cycle after a restart. It then checks that the next step still uses the old period and that the following steps use the new one.

// File: rtl/cd_timer_pkg.sv
package cd_timer_pkg;
  typedef enum logic [1:0] {
    RA_INIT = 2'd0,
    RA_CUR  = 2'd1,
    RA_DIV  = 2'd2,
    RA_VEC  = 2'd3
  } reg_addr_e;

  localparam int VB_MASK = 16;
  localparam int VB_PER  = 17;
  localparam int VB_STAT = 12;
  localparam int SHIFT_W = 3;
  localparam int DIV_W   = 4;

  // exponent of the prescaler divide; bit 2 of the setting is unused
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] cfg);
    logic [SHIFT_W-1:0] sel;
    sel = {cfg[3], cfg[1:0]};
    return sel + 3'd1;
  endfunction
endpackage

// File: rtl/cd_timer_presc.sv
module cd_timer_presc
  import cd_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             step
);
  localparam int PS_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] sh_q;
  logic [PS_W-1:0]    cnt_q;
  logic [PS_W-1:0]    lim;

  assign lim  = PS_W'((32'd1 << sh_q) - 32'd1);
  assign step = tick_en && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= div_shift('0);
    end else if (restart || step) begin
      cnt_q <= '0;
      sh_q  <= div_shift(div_cfg);
    end else if (tick_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sh_q == '0) || !step);
  // R2
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !step || (sh_q == '0));
endmodule

// File: rtl/cd_timer_count.sv
module cd_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             step,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] init,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = step && !ld && (cur == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      init <= '0;
    end else if (ld) begin
      cur  <= ld_val;
      init <= ld_val;
    end else if (step && cur != '0) begin
      if (cur == ONE) cur <= periodic ? init : '0;
      else            cur <= cur - ONE;
    end
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cur == $past(ld_val));
  // R3
  zero_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init == '0) |-> (cur == '0));
  // R4
  oneshot_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && cur == '0 && !ld) |=> cur == '0);
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> cur == init);
endmodule

// File: rtl/cd_timer_pend.sv
module cd_timer_pend #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  input  logic              clr,
  output logic [PEND_W-1:0] cnt
);
  localparam logic [PEND_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt != MAXV) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0)   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !dec && !clr) |=> cnt == MAXV);
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import cd_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sw_en,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector
);
  logic [DIV_W-1:0]  div_q;
  logic              mask_q, per_q;
  logic [VEC_W-1:0]  vec_q;
  logic              ld, step, expire, ack, vec_wr;
  logic [CNT_W-1:0]  cur, init;
  logic [PEND_W-1:0] pend;

  assign ld     = wr_en && (addr == RA_INIT);
  assign vec_wr = wr_en && (addr == RA_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (wr_en && addr == RA_DIV) div_q <= wdata[DIV_W-1:0];
      if (vec_wr) begin
        mask_q <= wdata[VB_MASK] | !sw_en;
        per_q  <= wdata[VB_PER];
        vec_q  <= wdata[VEC_W-1:0];
      end else if (!sw_en) begin
        mask_q <= 1'b1;
      end
    end
  end

  cd_timer_presc u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(ld),
    .div_cfg(div_q), .step(step)
  );

  cd_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(wdata), .step(step),
    .periodic(per_q), .cur(cur), .init(init), .expire(expire)
  );

  cd_timer_pend #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(expire), .dec(ack), .clr(!sw_en), .cnt(pend)
  );

  assign irq_valid  = (pend != '0) && !mask_q;
  assign irq_vector = vec_q;
  assign ack        = irq_valid && irq_ready;

  always_comb begin
    rdata = '0;
    case (addr)
      RA_INIT: rdata = init;
      RA_CUR:  rdata = cur;
      RA_DIV:  rdata[DIV_W-1:0] = div_q;
      RA_VEC: begin
        rdata[VB_MASK]   = mask_q;
        rdata[VB_PER]    = per_q;
        rdata[VB_STAT]   = irq_valid;
        rdata[VEC_W-1:0] = vec_q;
      end
      default: ;
    endcase
  end

  // R7
  sw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> mask_q);
  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && sw_en && !vec_wr) |=> irq_valid);
  // R9
  reset_mask_chk: assert property (@(posedge clk)
    !rst_n |=> mask_q && !irq_valid);
endmodule

// File: tb/cd_timer_tb.sv
module cd_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, sw_en = 1'b1, wr_en = 1'b0, irq_ready = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cd_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sw_en(sw_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drain(input logic [7:0] vec, input string req, output int n);
    n = 0;
    irq_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (irq_valid) begin
        n++;
        if (n == 1) chk({req, " vector"}, {24'd0, irq_vector}, {24'd0, vec});
      end
      @(negedge clk);
    end
    irq_ready = 1'b0;
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(2'd0, v); chk("R9 init", v, 32'd0);
    rd(2'd1, v); chk("R9 cur", v, 32'd0);
    rd(2'd2, v); chk("R9 div", v, 32'd0);
    rd(2'd3, v); chk("R9 entry", v, 32'h0001_0000);
    chk("R9 irq_valid", {31'd0, irq_valid}, 32'd0);

    // R1 R2 R4 R5 R6 sweep over every divide encoding, small counts, both modes
    for (int per = 0; per < 2; per++) begin
      for (int b = 0; b < 8; b++) begin
        for (int nn = 1; nn <= 3; nn++) begin
          logic [3:0] cfg;
          int d, k2, s, ecur, eexp;
          logic [7:0] vec;
          cfg = {b[2], (b == 5) ? 1'b1 : 1'b0, b[1:0]};
          d = 1 << ((b + 1) % 8);
          vec = 8'h20 + 8'(b);
          tick_en = 1'b0;
          wr(2'd3, (32'(per) << 17) | {24'd0, vec});
          wr(2'd2, {28'd0, cfg});
          tick_en = 1'b1;
          wr(2'd0, 32'(nn));
          repeat (d - 1) @(negedge clk);
          rd(2'd1, v); chk("R2 before first step", v, 32'(nn));
          k2 = nn * d + d;
          repeat (k2 - (d - 1)) @(negedge clk);
          tick_en = 1'b0;
          s = k2 / d;
          if (per == 1) begin
            ecur = nn - (s % nn);
            eexp = s / nn;
          end else begin
            ecur = 0;
            eexp = 1;
          end
          rd(2'd1, v);
          chk(per == 1 ? "R5 periodic count" : "R4 one-shot count", v, 32'(ecur));
          rd(2'd3, v);
          chk("R8 entry with status", v,
              (32'(per) << 17) | ((eexp > 0) ? 32'h1000 : 32'h0) | {24'd0, vec});
          drain(vec, "R6", n);
          chk(per == 1 ? "R5 R1 expiries" : "R4 R1 expiries", 32'(n), 32'(eexp));
          wr(2'd0, 32'd0);
        end
      end
    end

    // R10 divide change deferred to next step; R2 restart mid-run
    tick_en = 1'b0;
    wr(2'd3, 32'h0000_0000);
    wr(2'd2, 32'd0);
    tick_en = 1'b1;
    wr(2'd0, 32'd10);
    wr(2'd2, 32'd3);
    rd(2'd1, v); chk("R10 old period pending", v, 32'd10);
    @(negedge clk);
    rd(2'd1, v); chk("R10 step on old period", v, 32'd9);
    repeat (15) @(negedge clk);
    rd(2'd1, v); chk("R10 new period held", v, 32'd9);
    @(negedge clk);
    rd(2'd1, v); chk("R10 new period step", v, 32'd8);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'd5);
    rd(2'd1, v); chk("R2 restart load", v, 32'd5);
    repeat (15) @(negedge clk);
    rd(2'd1, v); chk("R2 restart phase", v, 32'd5);
    @(negedge clk);
    rd(2'd1, v); chk("R2 restart step", v, 32'd4);

    // R3 zero start value stops the timer
    wr(2'd0, 32'd0);
    repeat (50) @(negedge clk);
    rd(2'd1, v); chk("R3 stopped count", v, 32'd0);
    chk("R3 no event", {31'd0, irq_valid}, 32'd0);

    // R6 saturation: periodic, divide 1, start 1
    tick_en = 1'b0;
    wr(2'd3, 32'h0002_0055);
    wr(2'd2, 32'hB);
    tick_en = 1'b1;
    wr(2'd0, 32'd1);
    repeat (40) @(negedge clk);
    tick_en = 1'b0;
    drain(8'h55, "R6 sat", n);
    chk("R6 saturated pending", 32'(n), 32'd15);

    // R7 software disable
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    chk("R7 events before disable", {31'd0, irq_valid}, 32'd1);
    sw_en = 1'b0;
    @(negedge clk);
    chk("R7 valid dropped", {31'd0, irq_valid}, 32'd0);
    rd(2'd3, v); chk("R7 mask forced", v & 32'h0001_0000, 32'h0001_0000);
    wr(2'd3, 32'h0000_0011);
    rd(2'd3, v); chk("R7 unmask write blocked", v & 32'h0001_0000, 32'h0001_0000);
    sw_en = 1'b1;
    @(negedge clk);
    wr(2'd3, 32'h0000_0011);
    chk("R7 pending cleared", {31'd0, irq_valid}, 32'd0);
    wr(2'd0, 32'd0);

    // R8 field retention and ignored writes
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R8 entry fields", v, 32'h0003_00FF);
    wr(2'd2, 32'hFFFF_FFF5);
    rd(2'd2, v); chk("R8 divide bits", v, 32'h0000_0005);
    wr(2'd1, 32'd123);
    rd(2'd1, v); chk("R8 current write ignored", v, 32'd0);
    rd(2'd0, v); chk("R8 start value untouched", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule